// File: doc/BRIEF.md
# Packed Vector Rounding Right Shifter

This block shifts every unsigned lane of a packed 128-bit vector to the right. Each result is rounded to nearest, and a tie rounds upward. One 7-bit immediate carries both the lane size and the shift amount. Its 4-bit high part selects the lane size through its highest set bit. The full 7-bit value, taken away from twice the lane size, gives the shift. A full-width flag chooses between a 64-bit and a 128-bit vector. A scalar flag turns the operation into a single 64-bit lane. Encodings that do not decode to a legal operation are reported on two flags and do not disturb the stored result.

Operations come in on a valid/ready stream and leave on a second valid/ready stream, with one register stage in between. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle, so a continuous stream runs at one operation per clock. While `out_valid` is high and `out_ready` is low, the output holds still and no new operation is taken. The upstream side must then keep its operation on the inputs.

The rounding sum is formed one bit wider than the lane. A shift equal to the full lane width is therefore legal, and it returns the rounding carry.

Top module: `vec_round_shr`

## Requirements
- R1: In vector mode the lane size comes from the highest set bit of `in_imm_hi`: bit 3 set gives 64-bit lanes, bit 2 gives 32, bit 1 gives 16, and bit 0 alone gives 8.
- R2: The shift equals twice the lane size minus the unsigned 7-bit value {`in_imm_hi`,`in_imm_lo`}. For every legal encoding this lies from 1 to the lane size.
- R3: Each lane result is floor((x + 2^(s-1)) / 2^s) for the unsigned lane value x and shift s, kept to the lane width. A 64-bit lane shifted by 64 yields its most significant bit.
- R4: With `in_full`=0 in vector mode, only bits 63:0 are shifted and output bits 127:64 are zero. With `in_full`=1, all 128 bits are shifted.
- R5: In vector mode, `in_imm_hi`=0 sets `out_foreign`=1 and `out_undef`=0, and `out_data` keeps the previous result.
- R6: In vector mode, `in_imm_hi[3]`=1 together with `in_full`=0 sets `out_undef`=1 and `out_foreign`=0, and `out_data` keeps the previous result.
- R7: In scalar mode, a single 64-bit lane occupies bits 63:0. The shift is 128 minus the immediate, bits 127:64 are zero, and `in_full` has no effect. If `in_imm_hi[3]`=0 the encoding is undefined: `out_undef`=1 and `out_data` keeps the previous result.
- R8: `in_ready` = !`out_valid` || `out_ready`. An operation accepted on one edge appears on the outputs, with `out_valid`=1, after that edge. With no new acceptance, a drained output clears `out_valid`.
- R9: While `out_valid`=1 and `out_ready`=0, `out_data`, `out_undef`, `out_foreign` and `out_valid` stay unchanged.
- R10: After reset, `out_valid`, `out_undef` and `out_foreign` are 0 and `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_data | input | 128 | Packed source lanes |
| in_imm_hi | input | 4 | High part of the immediate (lane size selector) |
| in_imm_lo | input | 3 | Low part of the immediate |
| in_full | input | 1 | 1: 128-bit vector, 0: 64-bit vector |
| in_scalar | input | 1 | 1: single 64-bit lane operation |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 128 | Shifted and rounded lanes |
| out_undef | output | 1 | Undefined encoding for the accepted operation |
| out_foreign | output | 1 | Encoding does not belong to this operation |

## Verification
Draining a held result and accepting the next operation can fall in the same cycle. The bench keeps `out_ready` high through the whole sweep of lane sizes, immediates, width and scalar settings and data patterns, and it offers a new operation on the very cycle each result is checked. Every result must therefore match its own arithmetic model and must not be mixed up with its neighbour. A separate stall phase holds `out_ready` low while a second operation waits. It then releases both at once and checks that the held result stayed intact and that the waiting operation arrives next.

// File: rtl/rsh_pkg.sv
package rsh_pkg;
  localparam int LANE_KINDS = 4;
  localparam int IMM_W      = 7;
  localparam int SHIFT_W    = 7;

  typedef enum logic [1:0] {
    LANE8  = 2'd0,
    LANE16 = 2'd1,
    LANE32 = 2'd2,
    LANE64 = 2'd3
  } lane_kind_e;

  typedef struct packed {
    lane_kind_e         kind;
    logic [SHIFT_W-1:0] shift;
    logic               half;
    logic               undef;
    logic               foreign;
  } rsh_dec_t;
endpackage

// File: rtl/rsh_decode.sv
module rsh_decode
  import rsh_pkg::*;
(
  input  logic [3:0] imm_hi,
  input  logic [2:0] imm_lo,
  input  logic       full,
  input  logic       scalar,
  output rsh_dec_t   dec
);
  logic [7:0] span;

  always_comb begin
    dec = '0;
    if (scalar) begin
      dec.kind  = LANE64;
      dec.half  = 1'b1;
      dec.undef = !imm_hi[3];
    end else begin
      if (imm_hi[3])      dec.kind = LANE64;
      else if (imm_hi[2]) dec.kind = LANE32;
      else if (imm_hi[1]) dec.kind = LANE16;
      else                dec.kind = LANE8;
      dec.half    = !full;
      dec.foreign = (imm_hi == 4'd0);
      dec.undef   = imm_hi[3] && !full;
    end
    span      = 8'd16 << dec.kind;
    dec.shift = SHIFT_W'(span - {1'b0, imm_hi, imm_lo});
    if (!dec.undef && !dec.foreign) begin
      assert_shift_range_R2: assert (dec.shift != '0 && {1'b0, dec.shift} <= (span >> 1))
        else $error("shift out of range");
    end
  end
endmodule

// File: rtl/rsh_lane.sv
module rsh_lane #(
  parameter  int W  = 8,
  localparam int SW = $clog2(W) + 1
) (
  input  logic [W-1:0]  val,
  input  logic [SW-1:0] sh,
  output logic [W-1:0]  res
);
  logic [W:0] bias;
  logic [W:0] sum;
  logic [W:0] shifted;
  logic [W:0] floor_q;

  always_comb begin
    bias    = {{W{1'b0}}, 1'b1} << (sh - SW'(1));
    sum     = {1'b0, val} + bias;
    shifted = sum >> sh;
    res     = shifted[W-1:0];
    floor_q = {1'b0, val} >> sh;
    assert_round_step_R3: assert (({1'b0, res} == floor_q) || ({1'b0, res} == floor_q + 1'b1))
      else $error("rounded lane strays from truncated value");
  end
endmodule

// File: rtl/vec_round_shr.sv
module vec_round_shr
  import rsh_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [3:0]        in_imm_hi,
  input  logic [2:0]        in_imm_lo,
  input  logic              in_full,
  input  logic              in_scalar,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_undef,
  output logic              out_foreign
);
  localparam int HALF_W = DATA_W / 2;

  rsh_dec_t          dec;
  logic [DATA_W-1:0] by_kind [LANE_KINDS];
  logic [DATA_W-1:0] picked;
  logic [DATA_W-1:0] masked;
  logic              accept;

  rsh_decode u_dec (
    .imm_hi (in_imm_hi),
    .imm_lo (in_imm_lo),
    .full   (in_full),
    .scalar (in_scalar),
    .dec    (dec)
  );

  for (genvar k = 0; k < LANE_KINDS; k++) begin : g_kind
    localparam int W  = 8 << k;
    localparam int NL = DATA_W / W;
    localparam int SW = $clog2(W) + 1;
    logic [DATA_W-1:0] lanes_out;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      rsh_lane #(.W(W)) u_lane (
        .val (in_data[l*W +: W]),
        .sh  (dec.shift[SW-1:0]),
        .res (lanes_out[l*W +: W])
      );
    end
    assign by_kind[k] = lanes_out;
  end

  assign picked   = by_kind[dec.kind];
  assign masked   = dec.half ? {{HALF_W{1'b0}}, picked[HALF_W-1:0]} : picked;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_undef   <= 1'b0;
      out_foreign <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_undef   <= dec.undef;
      out_foreign <= dec.foreign;
      if (!dec.undef && !dec.foreign) out_data <= masked;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_undef) && $stable(out_foreign))
    else $error("held result changed");

  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid)
    else $error("accepted operation not presented");

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_scalar && !in_full && in_imm_hi != 4'd0 && !in_imm_hi[3]
    |=> out_data[DATA_W-1:HALF_W] == '0)
    else $error("upper half not cleared for 64-bit vector");

  assert_vec_undef_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_scalar && in_imm_hi[3] && !in_full
    |=> out_undef && !out_foreign && $stable(out_data))
    else $error("64-bit lane in 64-bit vector not flagged");

  assert_scalar_undef_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_scalar && !in_imm_hi[3] |=> out_undef && $stable(out_data))
    else $error("scalar without top immediate bit not flagged");

  assert_foreign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_scalar && in_imm_hi == 4'd0 |=> out_foreign && !out_undef && $stable(out_data))
    else $error("zero high field not reported as foreign");
endmodule

// File: tb/tb_vec_round_shr.sv
module tb_vec_round_shr;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic [3:0]   in_imm_hi = '0;
  logic [2:0]   in_imm_lo = '0;
  logic         in_full = 1'b0;
  logic         in_scalar = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic         out_undef;
  logic         out_foreign;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vec_round_shr dut (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_imm_hi, .in_imm_lo,
    .in_full, .in_scalar, .out_valid, .out_ready, .out_data, .out_undef, .out_foreign
  );

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  // Model of R1 (lane size), R2 (shift), R3 (rounding), R4..R7 (width, flags)
  function automatic void model(input logic [127:0] d, input logic [3:0] hi, input logic [2:0] lo,
                                input logic q, input logic sc, input logic [127:0] prev,
                                output logic [127:0] ed, output logic eu, output logic ef);
    int w, sh, lanes;
    logic [127:0] m, x, r;
    eu = 1'b0; ef = 1'b0; ed = '0;
    if (sc) begin
      w = 64; lanes = 1; eu = !hi[3];
    end else begin
      w = hi[3] ? 64 : hi[2] ? 32 : hi[1] ? 16 : 8;
      ef = (hi == 4'd0);
      eu = hi[3] && !q;
      lanes = (q ? 128 : 64) / w;
    end
    if (eu || ef) begin
      ed = prev;
      return;
    end
    sh = 2 * w - int'({hi, lo});
    m = {128{1'b1}} >> (128 - w);
    for (int l = 0; l < lanes; l++) begin
      x = (d >> (l * w)) & m;
      r = (x >> sh) + ((x >> (sh - 1)) & 128'd1);
      ed = ed | ((r & m) << (l * w));
    end
  endfunction

  function automatic logic [127:0] pattern(input int p);
    case (p)
      0: return {128{1'b1}};
      1: return {16{8'h80}};
      2: return {16{8'h55}};
      default: return {$urandom, $urandom, $urandom, $urandom};
    endcase
  endfunction

  function automatic string req_tag(input logic [3:0] hi, input logic q, input logic sc);
    if (sc) return "R7 R3";
    if (hi == 4'd0) return "R5";
    if (hi[3] && !q) return "R6";
    if (!q) return "R4 R1 R2 R3";
    return "R1 R2 R3";
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [127:0] prev, ed, d;
    logic eu, ef;
    logic [127:0] exp_d;
    logic exp_u, exp_f;
    string tag;
    bit pending;
    prev = '0; pending = 1'b0;
    exp_d = '0; exp_u = 1'b0; exp_f = 1'b0; tag = "";

    repeat (3) @(negedge clk);
    // R10 reset state
    check(out_valid == 1'b0 && out_data == '0 && out_undef == 1'b0 && out_foreign == 1'b0,
          "R10 reset", $sformatf("v=%b d=%h u=%b f=%b", out_valid, out_data, out_undef, out_foreign),
          "v=0 d=0 u=0 f=0");
    rst_n = 1'b1;

    // Streaming sweep: each check cycle also drains and accepts (R8)
    for (int sc = 0; sc < 2; sc++)
      for (int q = 0; q < 2; q++)
        for (int hi = 0; hi < 16; hi++)
          for (int lo = 0; lo < 8; lo++)
            for (int p = 0; p < 4; p++) begin
              @(negedge clk);
              if (pending) begin
                check(out_valid && in_ready && out_data == exp_d && out_undef == exp_u && out_foreign == exp_f,
                      tag, $sformatf("v=%b rdy=%b d=%h u=%b f=%b", out_valid, in_ready, out_data, out_undef, out_foreign),
                      $sformatf("v=1 rdy=1 d=%h u=%b f=%b", exp_d, exp_u, exp_f));
              end
              d = pattern(p);
              model(d, 4'(hi), 3'(lo), q[0], sc[0], prev, ed, eu, ef);
              exp_d = ed; exp_u = eu; exp_f = ef; prev = ed;
              tag = req_tag(4'(hi), q[0], sc[0]);
              in_data = d; in_imm_hi = 4'(hi); in_imm_lo = 3'(lo);
              in_full = q[0]; in_scalar = sc[0]; in_valid = 1'b1;
              pending = 1'b1;
            end
    @(negedge clk);
    check(out_valid && out_data == exp_d && out_undef == exp_u && out_foreign == exp_f, tag,
          $sformatf("d=%h u=%b f=%b", out_data, out_undef, out_foreign),
          $sformatf("d=%h u=%b f=%b", exp_d, exp_u, exp_f));
    in_valid = 1'b0;

    // R8: drained with nothing new clears out_valid
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R8 drain",
          $sformatf("v=%b rdy=%b", out_valid, in_ready), "v=0 rdy=1");

    // Stall phase: op A (64-bit lanes, shift 64, full width)
    out_ready = 1'b0;
    d = {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF};
    model(d, 4'h8, 3'd0, 1'b1, 1'b0, prev, ed, eu, ef);
    exp_d = ed; prev = ed;
    in_data = d; in_imm_hi = 4'h8; in_imm_lo = 3'd0; in_full = 1'b1; in_scalar = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check(out_valid && !in_ready && out_data == exp_d && exp_d == {64'd1, 64'd0}, "R8 R3 stall accept",
          $sformatf("v=%b rdy=%b d=%h", out_valid, in_ready, out_data),
          $sformatf("v=1 rdy=0 d=%h", {64'd1, 64'd0}));
    // op B waits: 8-bit lanes, shift 1
    d = {16{8'hFF}};
    in_data = d; in_imm_hi = 4'h1; in_imm_lo = 3'd7; in_full = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid && !in_ready && out_data == exp_d && !out_undef && !out_foreign, "R9 hold",
            $sformatf("v=%b rdy=%b d=%h", out_valid, in_ready, out_data),
            $sformatf("v=1 rdy=0 d=%h", exp_d));
    end
    model(d, 4'h1, 3'd7, 1'b1, 1'b0, prev, ed, eu, ef);
    exp_d = ed; prev = ed;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_data == exp_d && exp_d == {16{8'h80}}, "R8 R9 release",
          $sformatf("v=%b d=%h", out_valid, out_data), $sformatf("v=1 d=%h", {16{8'h80}}));
    @(negedge clk);
    check(out_valid == 1'b0, "R8 final drain", $sformatf("v=%b", out_valid), "v=0");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule